// File: doc/BRIEF.md
# Early-Prompt-Late Ranging Code Replica Generator

This block produces a local copy of a satellite's 1023-chip Gold ranging code for the correlators of one receiver channel. The code is not advanced by a fixed chip clock. A 32-bit phase accumulator adds a programmable step on every enabled sample cycle. Each carry out of the accumulator moves the replica forward by half a chip. Three replicas leave the block half a chip apart: early, prompt and late. The block also outputs the chip index of the prompt replica and a one-cycle pulse each time the code wraps from its last chip to its first.

The tracking loop that computes the step lies outside this block. A new step is written into a holding register and takes effect only when the next code period begins, so a correction never lands in the middle of an integration. A synchronous restart puts the replica back at chip zero. It also loads the step directly and latches the satellite selection.

Top module: `epl_code_replica`

## Requirements
- R1: After reset the chip index is 0, the half-chip phase is 0, the epoch output is low, satellite code 0 is selected and the prompt output is 1, which is the first chip of that code.
- R2: The chip at index n is G1[10] XOR G2[a] XOR G2[b]. G1 has feedback 1+x^3+x^10 and G2 has feedback 1+x^2+x^3+x^6+x^8+x^9+x^10. Both registers start at all ones at index 0. Satellite select value s picks the tap pair (a,b) of the standard code s+1 (0 gives 2,6; 1 gives 3,7; 31 gives 4,9). Select 0 gives the first ten chips 1100100000 and select 1 gives 1110010000.
- R3: On each cycle with the enable high, the accumulator adds the active step modulo 2^32. A carry advances the half-chip position by one. Outputs change at the clock edge that registers the carry, and the chip index stays within 0..1022.
- R4: With half-chip position h in 0..2045, prompt is the chip at h/2, early is the chip at (h+1)/2 and late is the chip at (h-1)/2, all taken modulo 2046 and rounded down.
- R5: Advancing from position 2045 wraps to position 0. The epoch output is then high for exactly the one cycle in which the chip index first reads 0.
- R6: A step-load strobe stores the step into a pending register without changing the active rate. The pending value becomes active at the next wrap. A strobe in the same cycle as a wrap is kept pending for the following wrap.
- R7: Restart takes priority over enable and step load. It sets the phase and position to 0, makes the step input both active and pending, and latches the satellite select. The chip index reads 0 with no epoch pulse on the next cycle.
- R8: While the enable and restart are both low, the accumulator, position and all outputs hold their values and no epoch pulse occurs.
- R9: The satellite select input has no effect except during a restart cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample-rate enable for the accumulator |
| restart_i | input | 1 | Synchronous restart to chip 0 |
| step_i | input | ACC_W | Phase step per enabled cycle |
| step_load_i | input | 1 | Writes step_i into the pending step register |
| sat_sel_i | input | 5 | Satellite code select, sampled on restart |
| early_o | output | 1 | Replica half a chip ahead of prompt |
| prompt_o | output | 1 | Prompt replica chip |
| late_o | output | 1 | Replica half a chip behind prompt |
| epoch_o | output | 1 | One-cycle pulse at the start of each code period |
| chip_idx_o | output | 10 | Chip index of the prompt replica |

## Verification
The bench targets the wrap from chip 1022 to chip 0, where late must read the last chip while early reads the first. A design that failed to reload its shift registers, or that computed the neighbouring chip from the wrong state, would produce a wrong early or late value there and a wrong sequence after the wrap. The bench writes a new step in the middle of a period and measures the chip rate on both sides of the next epoch. A design that applied the step at once would advance faster before the epoch. The bench also drives restart together with a step load and the enable, and changes the satellite select without a restart. These catch a block that gives a strobe priority over restart, or one that switches codes on the fly.

// File: rtl/epl_pkg.sv
package epl_pkg;

    localparam int unsigned LFSR_W   = 10;
    localparam int unsigned CODE_LEN = (1 << LFSR_W) - 1;
    localparam int unsigned IDX_W    = LFSR_W;
    localparam int unsigned SEL_W    = 5;

    typedef logic [LFSR_W:1] shreg_t;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
    } tap_pair_t;

    typedef struct packed {
        shreg_t            g1;
        shreg_t            g2;
        logic              prev;
        logic              cur;
        logic              nxt;
        logic              half;
        logic [IDX_W-1:0]  idx;
        logic [SEL_W-1:0]  sel;
        logic              epoch;
    } seq_state_t;

    // forward step of G1: feedback from stages 3 and 10
    function automatic shreg_t g1_fwd(shreg_t s);
        return {s[9:1], s[3] ^ s[10]};
    endfunction

    // inverse step of G1
    function automatic shreg_t g1_rev(shreg_t s);
        return {s[1] ^ s[4], s[10:2]};
    endfunction

    // forward step of G2: feedback from stages 2,3,6,8,9,10
    function automatic shreg_t g2_fwd(shreg_t s);
        return {s[9:1], s[2] ^ s[3] ^ s[6] ^ s[8] ^ s[9] ^ s[10]};
    endfunction

    // inverse step of G2
    function automatic shreg_t g2_rev(shreg_t s);
        return {s[1] ^ s[3] ^ s[4] ^ s[7] ^ s[9] ^ s[10], s[10:2]};
    endfunction

    function automatic tap_pair_t tap_lookup(logic [SEL_W-1:0] sel);
        tap_pair_t t;
        case (sel)
            5'd0:  t = '{4'd2, 4'd6};
            5'd1:  t = '{4'd3, 4'd7};
            5'd2:  t = '{4'd4, 4'd8};
            5'd3:  t = '{4'd5, 4'd9};
            5'd4:  t = '{4'd1, 4'd9};
            5'd5:  t = '{4'd2, 4'd10};
            5'd6:  t = '{4'd1, 4'd8};
            5'd7:  t = '{4'd2, 4'd9};
            5'd8:  t = '{4'd3, 4'd10};
            5'd9:  t = '{4'd2, 4'd3};
            5'd10: t = '{4'd3, 4'd4};
            5'd11: t = '{4'd5, 4'd6};
            5'd12: t = '{4'd6, 4'd7};
            5'd13: t = '{4'd7, 4'd8};
            5'd14: t = '{4'd8, 4'd9};
            5'd15: t = '{4'd9, 4'd10};
            5'd16: t = '{4'd1, 4'd4};
            5'd17: t = '{4'd2, 4'd5};
            5'd18: t = '{4'd3, 4'd6};
            5'd19: t = '{4'd4, 4'd7};
            5'd20: t = '{4'd5, 4'd8};
            5'd21: t = '{4'd6, 4'd9};
            5'd22: t = '{4'd1, 4'd3};
            5'd23: t = '{4'd4, 4'd6};
            5'd24: t = '{4'd5, 4'd7};
            5'd25: t = '{4'd6, 4'd8};
            5'd26: t = '{4'd7, 4'd9};
            5'd27: t = '{4'd8, 4'd10};
            5'd28: t = '{4'd1, 4'd6};
            5'd29: t = '{4'd2, 4'd7};
            5'd30: t = '{4'd3, 4'd8};
            default: t = '{4'd4, 4'd9};
        endcase
        return t;
    endfunction

    function automatic logic chip_bit(shreg_t g1, shreg_t g2, tap_pair_t t);
        return g1[LFSR_W] ^ g2[t.a] ^ g2[t.b];
    endfunction

    // state at chip 0 of a fresh period for the given code
    function automatic seq_state_t seq_init(logic [SEL_W-1:0] sel);
        seq_state_t s;
        tap_pair_t  t;
        shreg_t     ones;
        ones    = '1;
        t       = tap_lookup(sel);
        s.g1    = g1_fwd(ones);
        s.g2    = g2_fwd(ones);
        s.prev  = chip_bit(g1_rev(ones), g2_rev(ones), t);
        s.cur   = chip_bit(ones, ones, t);
        s.nxt   = chip_bit(s.g1, s.g2, t);
        s.half  = 1'b0;
        s.idx   = '0;
        s.sel   = sel;
        s.epoch = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/epl_code_nco.sv
module epl_code_nco #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             en_i,
    input  logic [ACC_W-1:0] step_i,
    input  logic             step_load_i,
    input  logic             swap_i,
    output logic             carry_o
);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic [ACC_W-1:0] active;
        logic [ACC_W-1:0] pending;
    } nco_state_t;

    nco_state_t q, d;
    logic [ACC_W:0] sum;

    always_comb begin
        d       = q;
        sum     = {1'b0, q.phase} + {1'b0, q.active};
        carry_o = en_i && !restart_i && sum[ACC_W];
        if (restart_i) begin
            d.phase   = '0;
            d.active  = step_i;
            d.pending = step_i;
        end else begin
            if (en_i)        d.phase   = sum[ACC_W-1:0];
            if (swap_i)      d.active  = q.pending;
            if (step_load_i) d.pending = step_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/epl_chip_seq.sv
module epl_chip_seq
    import epl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             wrap_o,
    output logic             early_o,
    output logic             prompt_o,
    output logic             late_o,
    output logic             epoch_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    seq_state_t q, d;
    tap_pair_t  taps;
    shreg_t     g1_n, g2_n;

    always_comb begin
        d       = q;
        d.epoch = 1'b0;
        taps    = tap_lookup(q.sel);
        wrap_o  = adv_i && q.half && (q.idx == LAST_IDX);
        g1_n    = g1_fwd(q.g1);
        g2_n    = g2_fwd(q.g2);
        if (restart_i) begin
            d = seq_init(sel_i);
        end else if (adv_i) begin
            if (!q.half) begin
                d.half = 1'b1;
            end else begin
                d.half = 1'b0;
                d.prev = q.cur;
                d.cur  = q.nxt;
                if (q.idx == LAST_IDX) begin
                    d.idx   = '0;
                    d.epoch = 1'b1;
                    g1_n    = g1_fwd('1);
                    g2_n    = g2_fwd('1);
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
                d.g1  = g1_n;
                d.g2  = g2_n;
                d.nxt = chip_bit(g1_n, g2_n, taps);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= seq_init('0);
        else         q <= d;
    end

    assign prompt_o = q.cur;
    assign early_o  = q.half ? q.nxt : q.cur;
    assign late_o   = q.half ? q.cur : q.prev;
    assign epoch_o  = q.epoch;
    assign idx_o    = q.idx;

endmodule

// File: rtl/epl_code_replica.sv
module epl_code_replica
    import epl_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [ACC_W-1:0] step_i,
    input  logic             step_load_i,
    input  logic [SEL_W-1:0] sat_sel_i,
    output logic             early_o,
    output logic             prompt_o,
    output logic             late_o,
    output logic             epoch_o,
    output logic [IDX_W-1:0] chip_idx_o
);

    logic half_carry;
    logic code_wrap;

    epl_code_nco #(.ACC_W(ACC_W)) i_nco (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .restart_i   (restart_i),
        .en_i        (en_i),
        .step_i      (step_i),
        .step_load_i (step_load_i),
        .swap_i      (code_wrap),
        .carry_o     (half_carry)
    );

    epl_chip_seq i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart_i),
        .adv_i     (half_carry),
        .sel_i     (sat_sel_i),
        .wrap_o    (code_wrap),
        .early_o   (early_o),
        .prompt_o  (prompt_o),
        .late_o    (late_o),
        .epoch_o   (epoch_o),
        .idx_o     (chip_idx_o)
    );

endmodule

// File: rtl/epl_code_replica_chk.sv
module epl_code_replica_chk
    import epl_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             restart_i,
    input logic             early_o,
    input logic             prompt_o,
    input logic             late_o,
    input logic             epoch_o,
    input logic [IDX_W-1:0] chip_idx_o
);

    logic vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= 1'b0;
        else         vld_q <= 1'b1;
    end

    a_r3_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_idx_o < IDX_W'(CODE_LEN));

    a_r5_epoch_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        epoch_o |-> chip_idx_o == '0);

    a_r5_epoch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        epoch_o |=> !epoch_o);

    a_r7_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (chip_idx_o == '0) && !epoch_o);

    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !restart_i) |=> $stable(chip_idx_o) && $stable(prompt_o)
            && $stable(early_o) && $stable(late_o) && !epoch_o);

    a_r4_chip_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && !$past(restart_i) && (chip_idx_o != $past(chip_idx_o)))
            |-> (late_o == $past(prompt_o)) && (prompt_o == $past(early_o)));

endmodule

bind epl_code_replica epl_code_replica_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .restart_i  (restart_i),
    .early_o    (early_o),
    .prompt_o   (prompt_o),
    .late_o     (late_o),
    .epoch_o    (epoch_o),
    .chip_idx_o (chip_idx_o)
);

// File: tb/test_epl_code_replica.sv
`timescale 1ns/1ps
module test_epl_code_replica;

    localparam int ACC_W = 32;
    localparam int NCHIP = 1023;
    localparam int NHALF = 2 * NCHIP;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             en_i = 1'b0;
    logic             restart_i = 1'b0;
    logic [ACC_W-1:0] step_i = '0;
    logic             step_load_i = 1'b0;
    logic [4:0]       sat_sel_i = '0;
    logic             early_o, prompt_o, late_o, epoch_o;
    logic [9:0]       chip_idx_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    epl_code_replica #(.ACC_W(ACC_W)) i_epl_code_replica (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .restart_i(restart_i),
        .step_i(step_i), .step_load_i(step_load_i), .sat_sel_i(sat_sel_i),
        .early_o(early_o), .prompt_o(prompt_o), .late_o(late_o),
        .epoch_o(epoch_o), .chip_idx_o(chip_idx_o)
    );

    // reference model
    bit          m_code [NCHIP];
    int          m_h;
    logic [31:0] m_phase, m_act, m_pend;
    int          m_sel;
    bit          m_epoch;

    function automatic void taps_of(input int s, output int a, output int b);
        int ta[32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
        int tb[32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};
        a = ta[s];
        b = tb[s];
    endfunction

    function automatic void build_code(input int s);
        bit r1 [1:10];
        bit r2 [1:10];
        int a, b;
        bit f1, f2;
        taps_of(s, a, b);
        for (int k = 1; k <= 10; k++) begin r1[k] = 1; r2[k] = 1; end
        for (int i = 0; i < NCHIP; i++) begin
            m_code[i] = r1[10] ^ r2[a] ^ r2[b];
            f1 = r1[3] ^ r1[10];
            f2 = r2[2] ^ r2[3] ^ r2[6] ^ r2[8] ^ r2[9] ^ r2[10];
            for (int k = 10; k >= 2; k--) begin r1[k] = r1[k-1]; r2[k] = r2[k-1]; end
            r1[1] = f1;
            r2[1] = f2;
        end
    endfunction

    task automatic model_step();
        logic [32:0] sum;
        logic [31:0] old_pend;
        m_epoch = 0;
        if (!rst_ni) begin
            m_h = 0; m_phase = 0; m_act = 0; m_pend = 0;
            if (m_sel != 0) begin m_sel = 0; build_code(0); end
        end else if (restart_i) begin
            m_h = 0; m_phase = 0; m_act = step_i; m_pend = step_i;
            if (m_sel != int'(sat_sel_i)) begin m_sel = int'(sat_sel_i); build_code(m_sel); end
        end else begin
            old_pend = m_pend;
            if (step_load_i) m_pend = step_i;
            if (en_i) begin
                sum = {1'b0, m_phase} + {1'b0, m_act};
                m_phase = sum[31:0];
                if (sum[32]) begin
                    m_h = m_h + 1;
                    if (m_h == NHALF) begin
                        m_h = 0; m_epoch = 1; m_act = old_pend;
                    end
                end
            end
        end
    endtask

    task automatic cmp(input string tag);
        int e_idx;
        bit e_p, e_e, e_l;
        bit ok;
        e_idx = m_h / 2;
        e_p   = m_code[m_h / 2];
        e_e   = m_code[((m_h + 1) % NHALF) / 2];
        e_l   = m_code[((m_h + NHALF - 1) % NHALF) / 2];
        ok = 1;
        total++;
        if (int'(chip_idx_o) != e_idx) begin ok = 0;
            $display("FAIL %s chip_idx act=%0d exp=%0d", tag, chip_idx_o, e_idx); end
        if (prompt_o !== e_p) begin ok = 0;
            $display("FAIL %s prompt at h=%0d act=%0b exp=%0b", tag, m_h, prompt_o, e_p); end
        if (early_o !== e_e) begin ok = 0;
            $display("FAIL %s early at h=%0d act=%0b exp=%0b", tag, m_h, early_o, e_e); end
        if (late_o !== e_l) begin ok = 0;
            $display("FAIL %s late at h=%0d act=%0b exp=%0b", tag, m_h, late_o, e_l); end
        if (epoch_o !== m_epoch) begin ok = 0;
            $display("FAIL %s epoch at h=%0d act=%0b exp=%0b", tag, m_h, epoch_o, m_epoch); end
        if (!ok) bad++;
    endtask

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic do_restart(input logic [31:0] st, input int sel, input string tag);
        restart_i = 1; step_i = st; sat_sel_i = 5'(sel); en_i = 1;
        tick(tag);
        restart_i = 0;
    endtask

    // R1: state after reset
    task automatic t_reset();
        rst_ni = 0;
        repeat (3) begin @(posedge clk); model_step(); end
        @(negedge clk);
        rst_ni = 1;
        tick("R1");
        check(chip_idx_o == 0, "R1 reset chip index", chip_idx_o, 0);
        check(prompt_o == 1'b1, "R1 reset prompt", prompt_o, 1);
        check(epoch_o == 1'b0, "R1 reset epoch", epoch_o, 0);
    endtask

    // R2: known first chips of two codes
    task automatic t_anchor(input int sel, input logic [9:0] exp_bits);
        logic [9:0] got;
        got = '0;
        do_restart(32'h8000_0000, sel, "R2");
        for (int i = 0; i < 41; i++) begin
            if (chip_idx_o < 10) got[9 - chip_idx_o] = prompt_o;
            tick("R2");
        end
        check(got == exp_bits, "R2 first ten chips", int'(got), int'(exp_bits));
    endtask

    // R5/R4: one full period, epoch seen exactly once
    task automatic t_full_epoch(input int sel);
        int ep;
        ep = 0;
        do_restart(32'h8000_0000, sel, "R5");
        for (int i = 0; i < 2 * NHALF + 8; i++) begin
            tick("R5");
            if (epoch_o) ep++;
        end
        check(ep == 1, "R5 epoch count over one period", ep, 1);
    endtask

    // R4: spacing under a quarter-rate step
    task automatic t_spacing();
        do_restart(32'h4000_0000, 12, "R4");
        for (int i = 0; i < 1500; i++) tick("R4");
    endtask

    // R3: fractional step, exact carry count, gapped enable
    task automatic t_fraction();
        do_restart(32'hC000_0000, 3, "R3");
        repeat (4) tick("R3");
        check(chip_idx_o == 1, "R3 three carries give chip 1", chip_idx_o, 1);
        for (int i = 0; i < 3000; i++) begin
            en_i = (i % 3) != 1;
            tick("R3");
        end
        en_i = 1;
        do_restart(32'h5555_5555, 20, "R3");
        for (int i = 0; i < 6200; i++) tick("R3");
    endtask

    // R8: hold while disabled
    task automatic t_hold();
        logic [9:0] idx0;
        logic       p0;
        do_restart(32'h8000_0000, 7, "R8");
        repeat (37) tick("R8");
        en_i = 0;
        idx0 = chip_idx_o; p0 = prompt_o;
        repeat (20) tick("R8");
        check(chip_idx_o == idx0, "R8 index held", chip_idx_o, idx0);
        check(prompt_o == p0, "R8 prompt held", prompt_o, p0);
        en_i = 1;
    endtask

    // R6: step write takes effect only at the next epoch
    task automatic t_step_defer();
        int idx0, waited;
        do_restart(32'h8000_0000, 25, "R6");
        repeat (2000) tick("R6");
        step_i = 32'hFFFF_FFFF; step_load_i = 1;
        tick("R6");
        step_load_i = 0; step_i = 32'h0000_0001;
        idx0 = chip_idx_o;
        repeat (40) tick("R6");
        check(int'(chip_idx_o) - idx0 == 10, "R6 old rate before epoch", int'(chip_idx_o) - idx0, 10);
        waited = 0;
        while (!epoch_o && waited < 3000) begin tick("R6"); waited++; end
        check(epoch_o == 1'b1, "R6 epoch reached", epoch_o, 1);
        repeat (100) tick("R6");
        check(chip_idx_o >= 45 && chip_idx_o <= 50, "R6 new rate after epoch", chip_idx_o, 49);
    endtask

    // R7: restart wins over load and enable
    task automatic t_restart();
        do_restart(32'h8000_0000, 14, "R7");
        repeat (300) tick("R7");
        step_load_i = 1;
        do_restart(32'hC000_0000, 9, "R7");
        step_load_i = 0;
        check(chip_idx_o == 0, "R7 index after restart", chip_idx_o, 0);
        check(epoch_o == 0, "R7 no epoch on restart", epoch_o, 0);
        repeat (4) tick("R7");
        check(chip_idx_o == 1, "R7 restart step active", chip_idx_o, 1);
        repeat (200) tick("R7");
    endtask

    // R9: select change without restart has no effect
    task automatic t_sel_ignored();
        do_restart(32'h8000_0000, 2, "R9");
        repeat (50) tick("R9");
        sat_sel_i = 5'd30;
        repeat (400) tick("R9");
        check(m_sel == 2, "R9 code kept", m_sel, 2);
    endtask

    initial begin
        m_sel = 0;
        build_code(0);
        m_h = 0; m_phase = 0; m_act = 0; m_pend = 0; m_epoch = 0;
        @(negedge clk);
        t_reset();
        en_i = 1;
        t_anchor(0, 10'b1100100000);
        t_anchor(1, 10'b1110010000);
        t_full_epoch(5);
        t_full_epoch(17);
        t_full_epoch(31);
        t_spacing();
        t_fraction();
        t_hold();
        t_step_defer();
        t_restart();
        t_sel_ignored();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule